// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor, one quotient bit per clock, in signed or unsigned mode. The quotient is placed in a low result register and the remainder in a high result register. The number of bit iterations depends on how many 8-bit groups are needed to hold the magnitude of the dividend. Leading groups that are entirely zero are skipped, so short operands finish early. Signed operation works on magnitudes and spends one extra cycle restoring the signs of the results.

A request is a one-cycle `start_i` pulse while the unit is idle. From the following cycle the unit reports `busy_o` and refuses further requests until the result is ready. A core uses that flag to keep any other multiply or divide from issuing. Completion is a one-cycle `done_o` pulse. In that cycle `busy_o` is already low, so a new request can be accepted in the done cycle. The results stay unchanged until the next completion.

Top module: `itdiv_early`

## Requirements
- R1: Unsigned latency: with g the number of 8-bit groups up to and including the highest non-zero group of the dividend (g is 1 for a dividend below 256, including zero), `done_o` is high in the cycle that follows the (8*g+1)-th rising edge, counting the edge that accepts `start_i` as the first. This gives 9, 17, 25 or 33 cycles.
- R2: Signed latency (`signed_i`=1): g is taken from the absolute value of the dividend, and the latency is 8*g+2 cycles, one more than unsigned. The worst case is 34 cycles.
- R3: Unsigned results: when `done_o` is high, `quot_o` holds the truncated quotient and `rem_o` holds the remainder, both as unsigned 32-bit values.
- R4: Signed results: the operands are two's complement. The quotient truncates toward zero and the remainder takes the sign of the dividend. The case -2147483648 / -1 yields quotient 0x80000000 and remainder 0.
- R5: `busy_o` is high from the cycle after an accepted start through the cycle before `done_o`. A `start_i` or operand change while `busy_o` is high is ignored: the running operation's timing and results are unchanged.
- R6: `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle. A `start_i` in the done cycle is accepted.
- R7: A zero divisor completes with the same latency as R1/R2. No fault is signalled and the result values are unspecified.
- R8: `quot_o` and `rem_o` change only in a cycle in which `done_o` is high.
- R9: After reset `busy_o` and `done_o` are 0 and `quot_o` and `rem_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request a division; honoured only while `busy_o` is low |
| signed_i | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend_i | input | 32 | Dividend, sampled at the accepting edge |
| divisor_i | input | 32 | Divisor, sampled at the accepting edge |
| busy_o | output | 1 | Unit reserved by a running division |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | 32 | Quotient (low result register) |
| rem_o | output | 32 | Remainder (high result register) |

## Verification
The embedded properties assume that `start_i` is a synchronous signal that matters only while the unit is idle. They also assume the operands are needed only at the accepting edge, and that the partial-remainder bound is meaningful only for a non-zero divisor. The bench drives every input at the falling edge. It raises `start_i` both while idle and deliberately in the middle of a running division with different operands, and it issues one request in a done cycle. Zero divisors are applied only to check completion timing and the holding of results.

// File: rtl/itdiv_pkg.sv
package itdiv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } itdiv_state_e;

endpackage

// File: rtl/itdiv_rst_sync.sv
module itdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/itdiv_prep.sv
module itdiv_prep #(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 8,
  localparam int NUM_GROUPS = DATA_W / GROUP_W,
  localparam int GCW        = $clog2(NUM_GROUPS + 1)
) (
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  input  logic              signed_i,
  output logic [DATA_W-1:0] a_aligned_o,
  output logic [DATA_W-1:0] b_mag_o,
  output logic              a_neg_o,
  output logic              b_neg_o,
  output logic [GCW-1:0]    groups_o
);

  logic [DATA_W-1:0]     a_mag;
  logic [NUM_GROUPS-1:0] grp_nz;
  int                    shamt;

  assign a_neg_o = signed_i & dividend_i[DATA_W-1];
  assign b_neg_o = signed_i & divisor_i[DATA_W-1];
  assign a_mag   = a_neg_o ? (~dividend_i + DATA_W'(1)) : dividend_i;
  assign b_mag_o = b_neg_o ? (~divisor_i  + DATA_W'(1)) : divisor_i;

  // one non-zero detector per byte group of the magnitude
  for (genvar gi = 0; gi < NUM_GROUPS; gi++) begin : g_grp
    assign grp_nz[gi] = |a_mag[gi*GROUP_W +: GROUP_W];
  end

  // significant group count, minimum one
  always_comb begin
    groups_o = GCW'(1);
    for (int i = 1; i < NUM_GROUPS; i++) begin
      if (grp_nz[i]) groups_o = GCW'(i + 1);
    end
  end

  // move the first significant group to the top so iteration starts there
  always_comb begin
    shamt       = GROUP_W * (NUM_GROUPS - int'(groups_o));
    a_aligned_o = a_mag << shamt;
  end

endmodule

// File: rtl/itdiv_step.sv
module itdiv_step #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] rem_i,
  input  logic [DATA_W-1:0] quo_i,
  input  logic [DATA_W-1:0] dvsr_i,
  output logic [DATA_W-1:0] rem_o,
  output logic [DATA_W-1:0] quo_o
);

  logic [DATA_W:0] trial;
  logic [DATA_W:0] diff;
  logic            fits;

  always_comb begin
    trial = {rem_i, quo_i[DATA_W-1]};
    diff  = trial - {1'b0, dvsr_i};
    fits  = ~diff[DATA_W] | (trial[DATA_W] & ~|dvsr_i);
    rem_o = fits ? diff[DATA_W-1:0] : trial[DATA_W-1:0];
    quo_o = {quo_i[DATA_W-2:0], fits};
  end

endmodule

// File: rtl/itdiv_fix.sv
module itdiv_fix #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] quo_i,
  input  logic [DATA_W-1:0] rem_i,
  input  logic              qneg_i,
  input  logic              rneg_i,
  output logic [DATA_W-1:0] quo_o,
  output logic [DATA_W-1:0] rem_o
);

  assign quo_o = qneg_i ? (~quo_i + DATA_W'(1)) : quo_i;
  assign rem_o = rneg_i ? (~rem_i + DATA_W'(1)) : rem_i;

endmodule

// File: rtl/itdiv_early.sv
module itdiv_early
  import itdiv_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] dividend_i,
  input  logic [DATA_W-1:0] divisor_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] quot_o,
  output logic [DATA_W-1:0] rem_o
);

  localparam int NUM_GROUPS = DATA_W / GROUP_W;
  localparam int GCW        = $clog2(NUM_GROUPS + 1);
  localparam int CW         = $clog2(DATA_W + 1);

  logic rst_sync_n;

  itdiv_state_e      state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] rem_q, rem_d, quo_q, quo_d;
  logic [DATA_W-1:0] dvsr_q;
  logic              sgn_q, qneg_q, rneg_q;
  logic              done_q, done_d;
  logic [DATA_W-1:0] quot_q, quot_d, remr_q, remr_d;
  logic              work_en, load_en, res_en;

  logic [DATA_W-1:0] a_aligned, b_mag;
  logic              a_neg, b_neg;
  logic [GCW-1:0]    groups;
  logic [DATA_W-1:0] step_rem, step_quo;
  logic [DATA_W-1:0] fix_quo, fix_rem;

  itdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  itdiv_prep #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) u_prep (
    .dividend_i  (dividend_i),
    .divisor_i   (divisor_i),
    .signed_i    (signed_i),
    .a_aligned_o (a_aligned),
    .b_mag_o     (b_mag),
    .a_neg_o     (a_neg),
    .b_neg_o     (b_neg),
    .groups_o    (groups)
  );

  itdiv_step #(.DATA_W(DATA_W)) u_step (
    .rem_i  (rem_q),
    .quo_i  (quo_q),
    .dvsr_i (dvsr_q),
    .rem_o  (step_rem),
    .quo_o  (step_quo)
  );

  itdiv_fix #(.DATA_W(DATA_W)) u_fix (
    .quo_i  (quo_q),
    .rem_i  (rem_q),
    .qneg_i (qneg_q),
    .rneg_i (rneg_q),
    .quo_o  (fix_quo),
    .rem_o  (fix_rem)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    quo_d   = quo_q;
    quot_d  = quot_q;
    remr_d  = remr_q;
    done_d  = 1'b0;
    work_en = 1'b0;
    load_en = 1'b0;
    res_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_en = 1'b1;
          work_en = 1'b1;
          rem_d   = '0;
          quo_d   = a_aligned;
          cnt_d   = CW'(GROUP_W * int'(groups));
          state_d = ST_ITER;
        end
      end
      ST_ITER: begin
        work_en = 1'b1;
        rem_d   = step_rem;
        quo_d   = step_quo;
        cnt_d   = cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          if (sgn_q) begin
            state_d = ST_FIX;
          end else begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
            res_en  = 1'b1;
            quot_d  = step_quo;
            remr_d  = step_rem;
          end
        end
      end
      ST_FIX: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        res_en  = 1'b1;
        quot_d  = fix_quo;
        remr_d  = fix_rem;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      rem_q   <= '0;
      quo_q   <= '0;
      dvsr_q  <= '0;
      sgn_q   <= 1'b0;
      qneg_q  <= 1'b0;
      rneg_q  <= 1'b0;
      quot_q  <= '0;
      remr_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (work_en) begin
        cnt_q <= cnt_d;
        rem_q <= rem_d;
        quo_q <= quo_d;
      end
      if (load_en) begin
        dvsr_q <= b_mag;
        sgn_q  <= signed_i;
        qneg_q <= a_neg ^ b_neg;
        rneg_q <= a_neg;
      end
      if (res_en) begin
        quot_q <= quot_d;
        remr_q <= remr_d;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign quot_o = quot_q;
  assign rem_o  = remr_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |=> !done_q); // R6
  AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |-> !busy_o); // R6
  AST_DIVISOR_KEPT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_o |=> $stable(dvsr_q)); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done_d |=> ($stable(quot_q) && $stable(remr_q))); // R8
  AST_PARTIAL_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_ITER && dvsr_q != '0) |-> (rem_q < dvsr_q)); // R3
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_ITER) |-> (cnt_q != '0 && cnt_q <= CW'(DATA_W))); // R1
  AST_SIGNED_FIXUP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done_q && sgn_q) |-> ($past(state_q) == ST_FIX)); // R2

endmodule

// File: tb/test_itdiv_early.sv
module test_itdiv_early;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        signed_i = 1'b0;
  logic [31:0] dividend_i = '0;
  logic [31:0] divisor_i = '0;
  logic        busy_o, done_o;
  logic [31:0] quot_o, rem_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  itdiv_early i_itdiv_early (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .signed_i   (signed_i),
    .dividend_i (dividend_i),
    .divisor_i  (divisor_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .quot_o     (quot_o),
    .rem_o      (rem_o)
  );

  // reference model state
  bit          m_busy, m_done, m_zero, m_zero_out;
  int          m_cnt;
  logic [31:0] m_qo, m_ro, p_q, p_r;
  string       m_lat_tag = "R9";
  string       m_val_tag = "R9";
  string       p_lat_tag, p_val_tag;

  task automatic ref_div(input logic [31:0] a, input logic [31:0] b, input bit s,
                         output logic [31:0] q, output logic [31:0] r, output int lat);
    logic [31:0] mag;
    int g;
    longint sa, sb;
    mag = (s && a[31]) ? (~a + 32'd1) : a;
    g = 1;
    for (int i = 1; i < 4; i++) if (mag[8*i +: 8] != 8'd0) g = i + 1;
    lat = 8 * g + (s ? 2 : 1);
    if (b == 32'd0) begin
      q = '0; r = '0;
    end else if (!s) begin
      q = a / b; r = a % b;
    end else begin
      sa = longint'(signed'(a));
      sb = longint'(signed'(b));
      q = 32'(sa / sb);
      r = 32'(sa % sb);
    end
  endtask

  always @(posedge clk) begin
    int lat;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cnt = 0; m_qo = '0; m_ro = '0; m_zero_out = 0;
    end else begin
      m_done = 0;
      m_zero_out = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_qo = p_q; m_ro = p_r;
          m_zero_out = m_zero;
          m_lat_tag = p_lat_tag; m_val_tag = p_val_tag;
        end
      end else if (start_i) begin
        ref_div(dividend_i, divisor_i, signed_i, p_q, p_r, lat);
        m_zero = (divisor_i == 32'd0);
        p_lat_tag = m_zero ? "R7" : (signed_i ? "R2" : "R1");
        p_val_tag = signed_i ? "R4" : "R3";
        m_cnt = lat - 1;
        m_busy = 1;
        m_lat_tag = p_lat_tag;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    if (m_done && m_zero_out) begin
      m_qo = quot_o; m_ro = rem_o;
    end
    chk(busy_o === m_busy, (m_busy || m_done) ? m_lat_tag : "R5", "busy_o",
        32'(busy_o), 32'(m_busy));
    chk(done_o === m_done, (m_busy || m_done) ? m_lat_tag : "R6", "done_o",
        32'(done_o), 32'(m_done));
    chk(quot_o === m_qo, m_done ? m_val_tag : "R8", "quot_o", quot_o, m_qo);
    chk(rem_o === m_ro, m_done ? m_val_tag : "R8", "rem_o", rem_o, m_ro);
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic launch(input logic [31:0] a, input logic [31:0] b, input bit s);
    start_i = 1'b1; signed_i = s; dividend_i = a; divisor_i = b;
    step();
    start_i = 1'b0; dividend_i = 32'hDEAD_BEEF; divisor_i = 32'h0000_0003;
  endtask

  task automatic wait_done();
    while (!done_o) step();
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input bit s);
    launch(a, b, s);
    wait_done();
    step(); step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state while reset is held
    chk(busy_o === 1'b0 && done_o === 1'b0, "R9", "reset flags", {30'd0, busy_o, done_o}, 32'd0);
    chk(quot_o === 32'd0 && rem_o === 32'd0, "R9", "reset results", quot_o | rem_o, 32'd0);
    rst_n = 1'b1;
    repeat (4) step();

    // R1 / R3 unsigned, each width class
    run(32'd100, 32'd7, 1'b0);
    run(32'd0, 32'd5, 1'b0);
    run(32'h0000_1234, 32'd10, 1'b0);
    run(32'h00AB_CDEF, 32'h0000_0101, 1'b0);
    run(32'hFFFF_FFFF, 32'd3, 1'b0);
    run(32'd17, 32'd200, 1'b0);
    run(32'h8000_0000, 32'h8000_0000, 1'b0);
    // R2 / R4 signed, sign mixes and widths
    run(32'd100, 32'd7, 1'b1);
    run(-32'sd100, 32'd7, 1'b1);
    run(32'd100, -32'sd7, 1'b1);
    run(-32'sd100, -32'sd7, 1'b1);
    run(-32'sd70000, 32'd13, 1'b1);
    run(32'h7FFF_FFFF, -32'sd2, 1'b1);
    run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1);
    run(-32'sd255, 32'd16, 1'b1);
    // R7 zero divisor, both modes
    run(32'h0012_3456, 32'd0, 1'b0);
    run(-32'sd5, 32'd0, 1'b1);
    // R5 start with other operands while busy is ignored
    launch(32'h0100_0000, 32'd9, 1'b0);
    step(); step();
    start_i = 1'b1; dividend_i = 32'd4; divisor_i = 32'd2; signed_i = 1'b1;
    step();
    start_i = 1'b0;
    wait_done();
    // R6 back-to-back request in the done cycle
    launch(32'd999, 32'd10, 1'b0);
    wait_done();
    launch(-32'sd1000, 32'd33, 1'b1);
    wait_done();
    repeat (5) step();

    summary();
    $finish;
  end

endmodule